// File: doc/BRIEF.md
# Hitless Phase-Offset Corrector

This block sits between the reference phase sampler and the phase detector of a digital PLL. Each comparison sample brings a reference phase and a feedback phase, both counted in master-clock ticks within one 8 kHz frame (2500 ticks). Without correction, the detector would see the raw difference. When the loop returns from holdover or moves to another reference input, that raw difference can be large, and the output clock would then jump.

A capture request marks such a moment. On the next accepted comparison sample, the block stores the raw difference as an offset and emits zero for that sample. From then on, it subtracts the stored offset from every raw difference. In effect, the detector tracks a virtual reference whose phase matched the feedback at the instant of capture. All differences wrap on the frame modulus, so the corrected error stays in a symmetric signed range. While the reference is flagged as failed, samples are dropped and no output is given.

Top module: `phase_offset_corrector`

## Requirements
- R1: After reset the stored offset is zero and `err_valid` is low, so until the first capture every corrected error equals the raw wrapped difference.
- R2: The raw difference is `ref_phase - fb_phase` reduced modulo 2500 into the range -1250 to +1249 (a difference of exactly +1250 becomes -1250; -1250 stays -1250).
- R3: A sample is accepted when `smp_valid` is high and `ref_fail` is low. Its result appears on `err_out` with `err_valid` high for exactly one cycle, one clock after the sample. At no other time is `err_valid` high.
- R4: A one-cycle `capture_req` arms a capture. The first accepted sample in a later cycle stores its raw difference as the new offset, and the output for that sample is 0.
- R5: When no capture takes place, the output is the raw difference minus the stored offset, reduced modulo 2500 into -1250 to +1249.
- R6: A sample taken while `ref_fail` is high produces no output and leaves the capture armed. The capture is then served by the first accepted sample.
- R7: A `capture_req` in the same cycle as an accepted sample does not affect that sample, which uses the old offset. The capture happens on the next accepted sample.
- R8: The offset holds its value between captures. Several requests before one accepted sample cause a single capture, and the sample after that capture is corrected normally.
- R9: The corrected subtraction wraps. For example, an offset of +1200 and a raw difference of -1200 give +100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Comparison sample strobe |
| ref_phase | input | 16 | Reference phase in ticks, below 2500 |
| fb_phase | input | 16 | Feedback phase in ticks, below 2500 |
| ref_fail | input | 1 | Reference currently failed; samples are dropped |
| capture_req | input | 1 | One-cycle request to realign the virtual reference |
| err_valid | output | 1 | Corrected error valid strobe |
| err_out | output | 17 | Signed corrected phase error, -1250 to +1249 |

## Verification
Every accepted sample yields its result exactly one clock later, because only one register stage lies between the sample inputs and `err_out`. The driver stamps each expected item with the cycle number at which it is due. The monitor compares that item at the falling edge of that cycle, and it treats any `err_valid` with no item due as a failure. Dropped samples and idle cycles push nothing, so any stray output is caught at once. The capture cases are ordered so that the expected values tell apart a capture on the request cycle from a capture on a later cycle.

// File: rtl/poc_pkg.sv
package poc_pkg;
    localparam int PHASE_W_DEF = 16;
    localparam int PERIOD_DEF  = 2500;
endpackage

// File: rtl/poc_wrap.sv
// Signed difference a - b folded into [-PERIOD/2, PERIOD/2 - 1].
// Both operands must lie within one period of each other.
module poc_wrap #(
    parameter int W      = 17,
    parameter int PERIOD = 2500
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] HALF_S = W'(PERIOD / 2);
    localparam logic signed [W-1:0] PER_S  = W'(PERIOD);

    logic signed [W-1:0] diff;

    always_comb begin
        diff = a - b;
        if (diff >= HALF_S)
            y = diff - PER_S;
        else if (diff < -HALF_S)
            y = diff + PER_S;
        else
            y = diff;
    end
endmodule

// File: rtl/poc_capture.sv
// Holds the armed-capture flag and the stored phase offset.
module poc_capture #(
    parameter int W = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                capture_req,
    input  logic signed [W-1:0] raw_err,
    output logic                cap_fire,
    output logic signed [W-1:0] offset
);
    typedef struct packed {
        logic                pending;
        logic signed [W-1:0] offset;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        cap_fire = accept & st_q.pending;
        if (cap_fire)
            st_d.offset = raw_err;
        // a request in the firing cycle re-arms for the next sample
        st_d.pending = (st_q.pending & ~cap_fire) | capture_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign offset = st_q.offset;
endmodule

// File: rtl/phase_offset_corrector.sv
module phase_offset_corrector #(
    parameter int PHASE_W = poc_pkg::PHASE_W_DEF,
    parameter int PERIOD  = poc_pkg::PERIOD_DEF,
    parameter int ERR_W   = PHASE_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [PHASE_W-1:0]      ref_phase,
    input  logic [PHASE_W-1:0]      fb_phase,
    input  logic                    ref_fail,
    input  logic                    capture_req,
    output logic                    err_valid,
    output logic signed [ERR_W-1:0] err_out
);
    typedef struct packed {
        logic                    valid;
        logic signed [ERR_W-1:0] err;
    } out_state_t;

    logic                    accept;
    logic                    cap_fire;
    logic signed [ERR_W-1:0] ref_s, fb_s;
    logic signed [ERR_W-1:0] raw_err, corr_err, offset_q;

    out_state_t out_d, out_q;

    assign accept = smp_valid & ~ref_fail;
    assign ref_s  = $signed({{(ERR_W-PHASE_W){1'b0}}, ref_phase});
    assign fb_s   = $signed({{(ERR_W-PHASE_W){1'b0}}, fb_phase});

    poc_wrap #(.W(ERR_W), .PERIOD(PERIOD)) u_raw (
        .a (ref_s),
        .b (fb_s),
        .y (raw_err)
    );

    poc_capture #(.W(ERR_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .capture_req (capture_req),
        .raw_err     (raw_err),
        .cap_fire    (cap_fire),
        .offset      (offset_q)
    );

    poc_wrap #(.W(ERR_W), .PERIOD(PERIOD)) u_corr (
        .a (raw_err),
        .b (offset_q),
        .y (corr_err)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = accept;
        if (accept)
            out_d.err = cap_fire ? '0 : corr_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign err_valid = out_q.valid;
    assign err_out   = out_q.err;
endmodule

// File: rtl/poc_checker.sv
module poc_checker #(
    parameter int W      = 17,
    parameter int PERIOD = 2500
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic                ref_fail,
    input logic                err_valid,
    input logic signed [W-1:0] err_out,
    input logic                cap_fire,
    input logic signed [W-1:0] offset
);
    localparam logic signed [W-1:0] HALF_S = W'(PERIOD / 2);

    // R2
    err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_out >= -HALF_S && err_out < HALF_S));

    // R3
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(smp_valid && !ref_fail));

    // R6
    fail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ref_fail) |=> !err_valid);

    // R4
    capture_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (err_valid && err_out == '0));

    // R8
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire |=> $stable(offset));
endmodule

bind phase_offset_corrector poc_checker #(.W(ERR_W), .PERIOD(PERIOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .ref_fail  (ref_fail),
    .err_valid (err_valid),
    .err_out   (err_out),
    .cap_fire  (cap_fire),
    .offset    (offset_q)
);

// File: tb/test_phase_offset_corrector.sv
module test_phase_offset_corrector;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic [15:0]        ref_phase = '0;
    logic [15:0]        fb_phase = '0;
    logic               ref_fail = 1'b0;
    logic               capture_req = 1'b0;
    logic               err_valid;
    logic signed [16:0] err_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    exp;
        int    due;
        string req;
    } item_t;
    item_t q[$];

    int offset_m  = 0;
    bit pending_m = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    phase_offset_corrector i_phase_offset_corrector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .ref_phase(ref_phase), .fb_phase(fb_phase), .ref_fail(ref_fail),
        .capture_req(capture_req), .err_valid(err_valid), .err_out(err_out)
    );

    function automatic int fold(int d);
        if (d >= 1250) return d - 2500;
        if (d < -1250) return d + 2500;
        return d;
    endfunction

    // driver: one cycle of stimulus plus the expected item
    task automatic send(bit sv, int r, int f, bit fail, bit req, string tag);
        int raw, e;
        @(negedge clk);
        smp_valid   = sv;
        ref_phase   = 16'(r);
        fb_phase    = 16'(f);
        ref_fail    = fail;
        capture_req = req;
        if (sv && !fail) begin
            raw = fold(r - f);
            if (pending_m) begin
                offset_m  = raw;
                pending_m = 1'b0;
                e = 0;
            end else begin
                e = fold(raw - offset_m);
            end
            q.push_back('{exp: e, due: cyc + 1, req: tag});
        end
        if (req) pending_m = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send(1'b0, 0, 0, 1'b0, 1'b0, "R3");
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (!err_valid || int'(err_out) != it.exp) begin
                    errors++;
                    $display("FAIL %s: valid=%0b err=%0d expected valid=1 err=%0d",
                             it.req, err_valid, err_out, it.exp);
                end
            end else if (err_valid) begin
                checks++;
                errors++;
                $display("FAIL R3: valid=1 err=%0d expected valid=0", err_out);
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (err_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: err_valid=%0b expected 0", err_valid);
        end
        rst_n = 1'b1;
        idle(2);
        // R1 / R2: zero offset, raw folding with boundaries
        send(1, 100, 50, 0, 0, "R1");
        send(1, 10, 2400, 0, 0, "R2");
        send(1, 2400, 10, 0, 0, "R2");
        send(1, 1250, 0, 0, 0, "R2");
        send(1, 0, 1250, 0, 0, "R2");
        send(1, 1249, 0, 0, 0, "R2");
        idle(3);
        // R4 / R5: capture then corrected tracking
        send(0, 0, 0, 0, 1, "R4");
        idle(2);
        send(1, 500, 100, 0, 0, "R4");
        send(1, 600, 100, 0, 0, "R5");
        send(1, 100, 500, 0, 0, "R5");
        // R9: corrected wrap
        send(0, 0, 0, 0, 1, "R9");
        send(1, 1300, 100, 0, 0, "R9");
        send(1, 100, 1300, 0, 0, "R9");
        // R6: failed reference drops sample, keeps capture armed
        send(0, 0, 0, 0, 1, "R6");
        send(1, 2000, 100, 1, 0, "R6");
        send(1, 50, 1000, 1, 0, "R6");
        idle(1);
        send(1, 700, 100, 0, 0, "R6");
        send(1, 800, 100, 0, 0, "R6");
        // R7: request coincident with a sample
        send(1, 900, 100, 0, 1, "R7");
        send(1, 900, 100, 0, 0, "R7");
        send(1, 1000, 100, 0, 0, "R7");
        // R8: repeated requests, single capture, then hold
        send(0, 0, 0, 0, 1, "R8");
        send(0, 0, 0, 0, 1, "R8");
        send(1, 300, 100, 0, 0, "R8");
        send(1, 400, 100, 0, 0, "R8");
        idle(20);
        send(1, 2499, 0, 0, 0, "R8");
        idle(4);
        done = 1'b1;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d results missing, expected 0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule